// File: doc/BRIEF.md
# Full-Frame CCD Line Readout Sequencer

This block sequences the vertical readout of a full-frame CCD. It waits in an idle state and watches an external integration trigger. The sensor collects light for as long as that trigger is high. When the trigger falls, the block walks the whole frame one line period at a time. For each line it issues a one-cycle line-start strobe and presents the line number and a flag that marks the line as a black reference line or an active line. A horizontal line reader downstream uses the strobe to start its own work.

A trigger rise seen while idle starts integration. It also fires a charge-reset pulse that lasts exactly one line period. Vertical sub-sampling keeps one line in every N through a transfer-gate enable. That enable is high only on the lines that are kept, and it stays low on the lines that are dropped. N is captured once, when readout begins. When the last line has finished, the sequencer goes back to idle and waits for the next rise of the trigger. The line period must be at least two clock cycles.

Top module: `frame_readout_seq`

## Requirements
- R1: While reset is held, line_start_o, cr_pulse_o and tg_en_o are 0, line_idx_o is 0 and line_black_o is 1.
- R2: One readout presents line indices 0 to N_LINES-1 in increasing order, where N_LINES = N_BLACK_TOP + N_ACTIVE + N_BLACK_BOT. line_black_o is 1 for the first N_BLACK_TOP indices and for the last N_BLACK_BOT indices, and it is 0 for the indices in between.
- R3: Readout starts on a falling trigger during integration. Call the clock edge that first samples the trigger low edge k. The strobe for line 0 is then high in the cycle that follows edge k+1.
- R4: Each line-start strobe is one cycle wide, and consecutive strobes in a frame are exactly LINE_CYCLES cycles apart.
- R5: line_idx_o and line_black_o are registered outputs. They change only in a cycle where line_start_o is high, and they keep their values after readout ends.
- R6: A trigger rise sampled while idle drives cr_pulse_o high for exactly LINE_CYCLES cycles, starting in the cycle after that edge.
- R7: A trigger rise during readout is ignored. It produces no charge-reset pulse, it does not alter the running frame and it starts no further frame.
- R8: Once the last line period has ended, the block is idle. tg_en_o is 0, and no strobe appears until a new rise and fall of the trigger.
- R9: In a frame with keep factor N, tg_en_o for line j is 1 exactly when j mod N = 0. It is set together with that line's strobe. N = 0 is treated as 1, and N = 1 keeps every line.
- R10: sub_n_i is sampled on the edge that starts readout. Changes to it during readout have no effect on that frame.
- R11: While the trigger is high during integration, no line-start strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Integration trigger; the sensor integrates while this is high |
| sub_n_i | input | SUB_W | Keep factor N for sub-sampling (one line in N kept) |
| line_start_o | output | 1 | One-cycle strobe at the start of each line period |
| line_idx_o | output | LINE_W | Index of the current line, counted from 0 |
| line_black_o | output | 1 | 1 for a black reference line, 0 for an active line |
| tg_en_o | output | 1 | Transfer-gate enable for the current line (0 drops the line) |
| cr_pulse_o | output | 1 | Charge-reset pulse, one line period long |

## Verification
The assertions take the trigger to be a clean synchronous level. They also assume a readout always lasts longer than one charge-reset pulse, so a new reset pulse can never start while the previous one is still running. The stimulus changes the trigger and the keep factor only on falling clock edges. It always holds the trigger high for at least one cycle before releasing it, and it raises the trigger during readout only at points well inside the frame. The keep factors used are 0, 1, 2, 3 and the largest value the port can carry.

// File: rtl/frs_pkg.sv
package frs_pkg;

    typedef enum logic [1:0] {
        FRS_IDLE  = 2'd0,
        FRS_INTEG = 2'd1,
        FRS_READ  = 2'd2
    } frs_state_e;

endpackage

// File: rtl/frs_edge.sv
module frs_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);

    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) lvl_q <= 1'b0;
        else         lvl_q <= lvl_d;
    end

    assign rise_o = lvl_i & ~lvl_q;
    assign fall_o = ~lvl_i & lvl_q;

endmodule

// File: rtl/frs_cr_timer.sv
module frs_cr_timer #(
    parameter  int unsigned LEN   = 1333,
    localparam int unsigned CNT_W = $clog2(LEN + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic pulse_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)            cnt_d = CNT_W'(LEN);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign pulse_o = (cnt_q != '0);

    // R6
    cr_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |-> !pulse_o);

    // R6
    cr_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_o && !start_i |=> (cnt_q < CNT_W'(LEN)));

endmodule

// File: rtl/frs_submask.sv
module frs_submask #(
    parameter int unsigned SUB_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [SUB_W-1:0] n_i,
    output logic             keep_o
);

    typedef struct packed {
        logic [SUB_W-1:0] n;
        logic [SUB_W-1:0] cnt;
    } mask_t;

    mask_t m_d, m_q;
    logic [SUB_W-1:0] nxt;

    always_comb begin
        m_d = m_q;
        nxt = m_q.cnt + 1'b1;
        if (load_i) begin
            m_d.n   = (n_i == '0) ? SUB_W'(1) : n_i;
            m_d.cnt = '0;
        end else if (step_i) begin
            m_d.cnt = (nxt >= m_q.n) ? '0 : nxt;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            m_q.n   <= SUB_W'(1);
            m_q.cnt <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign keep_o = (m_q.cnt == '0);

    // R9
    sub_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (m_q.n != '0) && (m_q.cnt < m_q.n));

    // R10
    n_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(m_q.n));

endmodule

// File: rtl/frame_readout_seq.sv
module frame_readout_seq
    import frs_pkg::*;
#(
    parameter  int unsigned N_BLACK_TOP = 6,
    parameter  int unsigned N_ACTIVE    = 1640,
    parameter  int unsigned N_BLACK_BOT = 6,
    parameter  int unsigned LINE_CYCLES = 1333,
    parameter  int unsigned SUB_W       = 4,
    localparam int unsigned N_LINES     = N_BLACK_TOP + N_ACTIVE + N_BLACK_BOT,
    localparam int unsigned LINE_W      = $clog2(N_LINES)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              trig_i,
    input  logic [SUB_W-1:0]  sub_n_i,
    output logic              line_start_o,
    output logic [LINE_W-1:0] line_idx_o,
    output logic              line_black_o,
    output logic              tg_en_o,
    output logic              cr_pulse_o
);

    localparam int unsigned CYC_W = $clog2(LINE_CYCLES + 1);
    localparam logic [LINE_W-1:0] TOP_END_L = LINE_W'(N_BLACK_TOP);
    localparam logic [LINE_W-1:0] ACT_END_L = LINE_W'(N_BLACK_TOP + N_ACTIVE);
    localparam logic [LINE_W-1:0] LAST_L    = LINE_W'(N_LINES - 1);
    localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(LINE_CYCLES - 1);

    typedef struct packed {
        frs_state_e        st;
        logic [CYC_W-1:0]  cyc;
        logic [LINE_W-1:0] line;
        logic [LINE_W-1:0] idx;
        logic              black;
        logic              strobe;
        logic              tg;
    } seq_t;

    seq_t s_d, s_q;
    logic rise, fall, keep, cr_start, sub_load, sub_step;

    frs_edge i_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (trig_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    frs_cr_timer #(.LEN(LINE_CYCLES)) i_cr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (cr_start),
        .pulse_o (cr_pulse_o)
    );

    frs_submask #(.SUB_W(SUB_W)) i_mask (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (sub_load),
        .step_i (sub_step),
        .n_i    (sub_n_i),
        .keep_o (keep)
    );

    always_comb begin
        s_d        = s_q;
        s_d.strobe = 1'b0;
        cr_start   = 1'b0;
        sub_load   = 1'b0;
        sub_step   = 1'b0;
        unique case (s_q.st)
            FRS_IDLE: begin
                if (rise) begin
                    s_d.st   = FRS_INTEG;
                    cr_start = 1'b1;
                end
            end
            FRS_INTEG: begin
                if (fall) begin
                    s_d.st   = FRS_READ;
                    s_d.cyc  = '0;
                    s_d.line = '0;
                    sub_load = 1'b1;
                end
            end
            FRS_READ: begin
                if (s_q.cyc == '0) begin
                    s_d.strobe = 1'b1;
                    s_d.idx    = s_q.line;
                    s_d.black  = (s_q.line < TOP_END_L) || (s_q.line >= ACT_END_L);
                    s_d.tg     = keep;
                    sub_step   = 1'b1;
                end
                if (s_q.cyc == CYC_LAST) begin
                    s_d.cyc = '0;
                    if (s_q.line == LAST_L) begin
                        s_d.st = FRS_IDLE;
                        s_d.tg = 1'b0;
                    end else begin
                        s_d.line = s_q.line + 1'b1;
                    end
                end else begin
                    s_d.cyc = s_q.cyc + 1'b1;
                end
            end
            default: s_d.st = FRS_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q.st     <= FRS_IDLE;
            s_q.cyc    <= '0;
            s_q.line   <= '0;
            s_q.idx    <= '0;
            s_q.black  <= 1'b1;
            s_q.strobe <= 1'b0;
            s_q.tg     <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign line_start_o = s_q.strobe;
    assign line_idx_o   = s_q.idx;
    assign line_black_o = s_q.black;
    assign tg_en_o      = s_q.tg;

    // R5
    idx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !line_start_o |-> ($stable(line_idx_o) && $stable(line_black_o)));

    // R2
    idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (line_start_o && line_idx_o != '0) |-> (line_idx_o == $past(line_idx_o) + 1'b1));

    // R11
    strobe_in_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        line_start_o |-> (s_q.st == FRS_READ));

    // R7
    cr_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cr_pulse_o) |-> $past(s_q.st == FRS_IDLE && rise));

    // R8
    idle_tg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.st != FRS_READ) |-> !tg_en_o);

endmodule

// File: tb/test_frame_readout_seq.sv
module test_frame_readout_seq;

    localparam int BT = 2;
    localparam int ACT = 5;
    localparam int BB = 2;
    localparam int L = 4;
    localparam int SW = 4;
    localparam int T = BT + ACT + BB;
    localparam int LW = $clog2(T);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig = 1'b0;
    logic [SW-1:0] sub_n = SW'(1);
    logic          line_start_o, line_black_o, tg_en_o, cr_pulse_o;
    logic [LW-1:0] line_idx_o;

    frame_readout_seq #(
        .N_BLACK_TOP (BT),
        .N_ACTIVE    (ACT),
        .N_BLACK_BOT (BB),
        .LINE_CYCLES (L),
        .SUB_W       (SW)
    ) i_frame_readout_seq (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .trig_i       (trig),
        .sub_n_i      (sub_n),
        .line_start_o (line_start_o),
        .line_idx_o   (line_idx_o),
        .line_black_o (line_black_o),
        .tg_en_o      (tg_en_o),
        .cr_pulse_o   (cr_pulse_o)
    );

    always #5 clk = ~clk;

    typedef struct { int idx; bit black; bit tg; } item_t;
    item_t exp_q[$];

    int  n_checks = 0, n_fail = 0;
    int  cyc = 0, fall_cyc = 0, last_cyc = 0;
    int  cr_run = 0, cr_seen = 0, exp_cr = 0;
    bit  mon_en = 0, done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops expected lines and compares, tracks charge-reset pulses
    always @(negedge clk) begin
        if (mon_en) begin
            if (line_start_o) begin
                if (exp_q.size() == 0) begin
                    check(0, "R8 R11 unexpected line strobe", int'(line_idx_o), -1);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    check(int'(line_idx_o) == it.idx, "R2 line index", int'(line_idx_o), it.idx);
                    check(line_black_o == it.black, "R2 black flag", int'(line_black_o), int'(it.black));
                    check(tg_en_o == it.tg, "R9 R10 transfer gate", int'(tg_en_o), int'(it.tg));
                    if (it.idx == 0)
                        check(cyc == fall_cyc + 2, "R3 first strobe delay", cyc - fall_cyc, 2);
                    else
                        check(cyc - last_cyc == L, "R4 strobe spacing", cyc - last_cyc, L);
                    last_cyc = cyc;
                end
            end
            if (cr_pulse_o) begin
                cr_run++;
            end else if (cr_run > 0) begin
                check(cr_run == L, "R6 charge reset length", cr_run, L);
                cr_seen++;
                cr_run = 0;
            end
        end
    end

    // driver: runs one frame and pushes its expected lines
    task automatic run_frame(input int n, input int integ, input bit mid_rise, input int n_late);
        int neff;
        neff = (n == 0) ? 1 : n;
        @(negedge clk) trig = 1'b1;
        exp_cr++;
        @(negedge clk);
        check(cr_pulse_o == 1'b1, "R6 charge reset start", int'(cr_pulse_o), 1);
        repeat (integ) @(negedge clk);
        sub_n    = SW'(n);
        trig     = 1'b0;
        fall_cyc = cyc;
        for (int j = 0; j < T; j++) begin
            item_t it;
            it.idx   = j;
            it.black = (j < BT) || (j >= BT + ACT);
            it.tg    = (j % neff) == 0;
            exp_q.push_back(it);
        end
        if (n_late >= 0) begin
            repeat (3) @(negedge clk);
            sub_n = SW'(n_late);
        end
        if (mid_rise) begin
            repeat (8) @(negedge clk);
            trig = 1'b1;
            repeat (4) @(negedge clk);
            trig = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
        repeat (L + 2) @(negedge clk);
        check(tg_en_o == 1'b0, "R8 transfer gate low in idle", int'(tg_en_o), 0);
        check(int'(line_idx_o) == T - 1, "R5 index held after frame", int'(line_idx_o), T - 1);
        check(line_black_o == 1'b1, "R5 black flag held after frame", int'(line_black_o), 1);
        check(cr_seen == exp_cr, "R6 R7 charge reset count", cr_seen, exp_cr);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(line_start_o == 1'b0, "R1 strobe in reset", int'(line_start_o), 0);
        check(cr_pulse_o == 1'b0, "R1 charge reset in reset", int'(cr_pulse_o), 0);
        check(tg_en_o == 1'b0, "R1 transfer gate in reset", int'(tg_en_o), 0);
        check(int'(line_idx_o) == 0, "R1 index in reset", int'(line_idx_o), 0);
        check(line_black_o == 1'b1, "R1 black flag in reset", int'(line_black_o), 1);
        rst_n  = 1'b1;
        mon_en = 1'b1;

        run_frame(1, 20, 1'b0, -1);   // long integration, all lines kept
        run_frame(3, 5, 1'b1, -1);    // rise during readout ignored
        run_frame(2, 3, 1'b0, 7);     // keep factor changed mid-frame
        run_frame(0, 2, 1'b0, -1);    // zero treated as one
        run_frame(15, 1, 1'b0, -1);   // largest keep factor

        repeat (3 * L * T) @(negedge clk);
        check(int'(line_idx_o) == T - 1, "R7 R8 no further frame", int'(line_idx_o), T - 1);
        check(cr_seen == exp_cr, "R7 no extra charge reset", cr_seen, exp_cr);
        check(exp_q.size() == 0, "R2 all lines seen", exp_q.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule